// File: doc/BRIEF.md
# Waveform Raster Renderer

This block turns a stream of signed 8-bit samples into a simple oscilloscope picture on a 640x480 VGA raster. Each sample accepted on the input stream goes into a 512-entry dual-port buffer at a write pointer. The pointer advances by one per sample and wraps, so the buffer always holds the most recent 512 samples. The raster side generates horizontal and vertical timing. It uses the current column as the read address of the buffer, converts the returned sample to a screen row and lights the pixel when that row equals the current line. The result is a one-pixel-thick trace with one dot per column across the left 512 columns.

The buffer read is synchronous, so the sample for a column comes back one clock after its address. The line number, the sync pulses and the active-area flags pass through one matching register stage. This keeps every output pixel aligned with its own sync timing. The input stream holds its ready high at all times: it applies no back-pressure, and a sample is taken on every clock in which valid is high.

Top module: `wave_raster_top`

## Requirements
- R1: `smp_ready` is always 1. Every clock with `smp_valid` high writes `smp_data` at the write pointer. The pointer starts at 0 and advances by one per write, wrapping from 511 to 0, so the 513th sample replaces entry 0.
- R2: The buffer is read with a registered (one-cycle) read. Sync and active flags are delayed by the same one cycle, so the pixel shown with a given sync state belongs to the same raster position.
- R3: A line is 800 clocks long with 640 active. `vga_hs_n` is low for the clocks at line positions 656 to 751 and high otherwise (timing parameters scale this).
- R4: A frame is 525 lines with 480 active. `vga_vs_n` is low on lines 490 and 491 and high otherwise.
- R5: A sample maps to screen row = (sample with bit 7 inverted, read as unsigned 0..255) + 112. So -128 maps to row 112, 0 to row 240 and 127 to row 367.
- R6: A pixel is lit, with all three colour outputs at 1, exactly when it lies in the active area, its column is below 512 and its line equals the mapped row of that column's stored sample. Each such column therefore shows exactly one lit pixel per frame.
- R7: All colour outputs are 0 outside the 640x480 active area and in columns 512 to 639.
- R8: When a write and a read hit the same buffer entry in the same clock, the read returns the content from before that write.
- R9: While `rst_n` is low, the colour outputs are 0 and both sync outputs are 1. The raster and the write pointer restart from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready, held at 1 |
| smp_data | input | 8 | Two's complement sample |
| vga_r | output | 1 | Red |
| vga_g | output | 1 | Green |
| vga_b | output | 1 | Blue |
| vga_hs_n | output | 1 | Horizontal sync, active low |
| vga_vs_n | output | 1 | Vertical sync, active low |

## Verification
The one pair of functions that can meet in a single clock is a sample write from the stream and the raster read of the same buffer entry. The bench provokes this by timing a write to land on entry 100 in the exact clock the raster reads column 100 on line 40. The new value maps to row 40 and the old value maps to row 44. The collision is judged at the colour outputs: column 100 must stay dark for the whole frame. A lit pixel at line 40 would show that the new value leaked into the read.

// File: rtl/wave_raster_pkg.sv
package wave_raster_pkg;

  localparam int SAMPLE_W = 8;

  // Raster control flags travelling alongside a pixel position
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic active;
    logic col_ok;
  } raster_ctl_t;

  localparam raster_ctl_t CTL_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1, active: 1'b0, col_ok: 1'b0};

endpackage

// File: rtl/raster_timing.sv
module raster_timing
  import wave_raster_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int DEPTH  = 512,
  parameter int H_W    = 10,
  parameter int V_W    = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [H_W-1:0] hcnt,
  output logic [V_W-1:0] vcnt,
  output raster_ctl_t    ctl
);

  localparam int H_TOT  = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT  = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG = H_ACT + H_FP;
  localparam int HS_END = HS_BEG + H_SYNC;
  localparam int VS_BEG = V_ACT + V_FP;
  localparam int VS_END = VS_BEG + V_SYNC;

  logic line_end;
  logic frame_end;

  assign line_end  = (hcnt == H_W'(H_TOT - 1));
  assign frame_end = (vcnt == V_W'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_comb begin
    ctl.hsync_n = !((hcnt >= H_W'(HS_BEG)) && (hcnt < H_W'(HS_END)));
    ctl.vsync_n = !((vcnt >= V_W'(VS_BEG)) && (vcnt < V_W'(VS_END)));
    ctl.active  = (hcnt < H_W'(H_ACT)) && (vcnt < V_W'(V_ACT));
    ctl.col_ok  = (hcnt < H_W'(DEPTH));
  end

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt < H_W'(H_TOT));

  // R4
  vline_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcnt != $past(vcnt)) |-> ($past(hcnt) == H_W'(H_TOT - 1)));

endmodule

// File: rtl/sample_buffer.sv
module sample_buffer #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr;

  // Write pointer wraps naturally at the top of the address range
  always_ff @(posedge clk) begin
    if (!rst_n) wptr <= '0;
    else if (wr_en) wptr <= wptr + 1'b1;
  end

  // Storage with registered read; a same-entry write is seen on the next read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

  // R1
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wptr == $past(wptr) + 1'b1));

  // R1
  wptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (wptr == $past(wptr)));

endmodule

// File: rtl/trace_compare.sv
module trace_compare
  import wave_raster_pkg::*;
#(
  parameter int DW      = 8,
  parameter int V_W     = 10,
  parameter int ROW_OFS = 112
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [V_W-1:0] vcnt,
  input  raster_ctl_t    ctl,
  input  logic [DW-1:0]  rd_data,
  output logic           pix,
  output logic           hsync_n,
  output logic           vsync_n
);

  localparam int RW = ((V_W > DW) ? V_W : DW) + 2;

  logic [V_W-1:0] v_q;
  raster_ctl_t    ctl_q;
  logic [DW-1:0]  ofs_bin;
  logic [RW-1:0]  row;
  logic [RW-1:0]  line;

  // One stage matching the buffer read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= '0;
      ctl_q <= CTL_IDLE;
    end else begin
      v_q   <= vcnt;
      ctl_q <= ctl;
    end
  end

  always_comb begin
    ofs_bin = {~rd_data[DW-1], rd_data[DW-2:0]};
    row     = RW'(ofs_bin) + RW'(ROW_OFS);
    line    = RW'(v_q);
    pix     = ctl_q.active && ctl_q.col_ok && (row == line);
    hsync_n = ctl_q.hsync_n;
    vsync_n = ctl_q.vsync_n;
  end

endmodule

// File: rtl/wave_raster_top.sv
module wave_raster_top
  import wave_raster_pkg::*;
#(
  parameter int H_ACT   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_ACT   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int DEPTH   = 512,
  parameter int ROW_OFS = 112
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  output logic                smp_ready,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                vga_r,
  output logic                vga_g,
  output logic                vga_b,
  output logic                vga_hs_n,
  output logic                vga_vs_n
);

  localparam int AW    = $clog2(DEPTH);
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int H_W   = $clog2(H_TOT);
  localparam int V_W   = $clog2(V_TOT);

  logic [H_W-1:0]      hcnt;
  logic [V_W-1:0]      vcnt;
  raster_ctl_t         ctl;
  logic [SAMPLE_W-1:0] rd_data;
  logic                pix;

  assign smp_ready = 1'b1;

  raster_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .DEPTH(DEPTH), .H_W(H_W), .V_W(V_W)
  ) u_timing (
    .clk  (clk),
    .rst_n(rst_n),
    .hcnt (hcnt),
    .vcnt (vcnt),
    .ctl  (ctl)
  );

  sample_buffer #(
    .DEPTH(DEPTH), .DW(SAMPLE_W), .AW(AW)
  ) u_buffer (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (smp_valid && smp_ready),
    .wr_data(smp_data),
    .rd_addr(hcnt[AW-1:0]),
    .rd_data(rd_data)
  );

  trace_compare #(
    .DW(SAMPLE_W), .V_W(V_W), .ROW_OFS(ROW_OFS)
  ) u_compare (
    .clk    (clk),
    .rst_n  (rst_n),
    .vcnt   (vcnt),
    .ctl    (ctl),
    .rd_data(rd_data),
    .pix    (pix),
    .hsync_n(vga_hs_n),
    .vsync_n(vga_vs_n)
  );

  assign vga_r = pix;
  assign vga_g = pix;
  assign vga_b = pix;

  // R2
  sync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vga_hs_n == $past(ctl.hsync_n)) && (vga_vs_n == $past(ctl.vsync_n)));

  // R7
  lit_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vga_r |-> (($past(hcnt) < H_W'(DEPTH)) && ($past(vcnt) < V_W'(V_ACT))));

endmodule

// File: tb/test_wave_raster_top.sv
module test_wave_raster_top;

  localparam int H_ACT = 640, H_FP = 4, H_SYNC = 8, H_BP = 4;
  localparam int V_ACT = 80,  V_FP = 2, V_SYNC = 2, V_BP = 4;
  localparam int DEPTH = 512, ROW_OFS = 8;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int COLL_COL = 100, COLL_LINE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [7:0] smp_data = '0;
  logic vga_r, vga_g, vga_b, vga_hs_n, vga_vs_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] model [DEPTH];
  int lit_cnt [DEPTH];
  int lit_row [DEPTH];

  always #10 clk = ~clk;

  wave_raster_top #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .DEPTH(DEPTH), .ROW_OFS(ROW_OFS)
  ) i_wave_raster_top (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
    .vga_hs_n(vga_hs_n), .vga_vs_n(vga_vs_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int row_of(input logic [7:0] s);
    return int'(s ^ 8'h80) + ROW_OFS;
  endfunction

  task automatic put_sample(input logic [7:0] s);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = s;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // R9: outputs during reset
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(vga_r == 1'b0 && vga_g == 1'b0 && vga_b == 1'b0, "R9 rgb", int'(vga_r), 0);
    check(vga_hs_n == 1'b1, "R9 hsync", int'(vga_hs_n), 1);
    check(vga_vs_n == 1'b1, "R9 vsync", int'(vga_vs_n), 1);
    check(smp_ready == 1'b1, "R1 ready", int'(smp_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: ramp into all entries; ramp rows are ROW_OFS + (c mod 64)
  task automatic t_preload();
    for (int c = 0; c < DEPTH; c++) begin
      model[c] = 8'((c % 64) + 128);
      put_sample(model[c]);
      if (!smp_ready) check(1'b0, "R1 ready", 0, 1);
    end
  endtask

  // R1: wrap; next 100 samples land in entries 0..99, entry 5 changed
  task automatic t_rewrite_wrap();
    for (int c = 0; c < COLL_COL; c++) begin
      if (c == 5) model[c] = 8'hBE;   // -66 -> row ROW_OFS+62
      put_sample(model[c]);
    end
  endtask

  // R2..R8: one full frame observed at the pins, with a timed colliding write
  task automatic t_frame_scan();
    int px, py, hs_err, vs_err, stray_cols, stray_blank, rgb_err;
    logic prev_vs;
    logic [7:0] old_val;
    hs_err = 0; vs_err = 0; stray_cols = 0; stray_blank = 0; rgb_err = 0;
    for (int c = 0; c < DEPTH; c++) begin lit_cnt[c] = 0; lit_row[c] = -1; end
    old_val = model[COLL_COL];
    prev_vs = 1'b1;
    @(negedge clk);
    while (!(prev_vs && !vga_vs_n)) begin
      prev_vs = vga_vs_n;
      @(negedge clk);
    end
    px = 0;
    py = V_ACT + V_FP;
    for (int n = 0; n < H_TOT * V_TOT; n++) begin
      bit exp_hs, exp_vs, act;
      exp_hs = !(px >= H_ACT + H_FP && px < H_ACT + H_FP + H_SYNC);
      exp_vs = !(py >= V_ACT + V_FP && py < V_ACT + V_FP + V_SYNC);
      act    = (px < H_ACT) && (py < V_ACT);
      if (vga_hs_n != exp_hs) hs_err++;
      if (vga_vs_n != exp_vs) vs_err++;
      if (vga_r != vga_g || vga_r != vga_b) rgb_err++;
      if (vga_r) begin
        if (!act) stray_blank++;
        else if (px >= DEPTH) stray_cols++;
        else begin
          lit_cnt[px]++;
          lit_row[px] = py;
        end
      end
      // R8: write lands in the clock that reads column COLL_COL on COLL_LINE
      smp_valid = 1'b0;
      if (px == COLL_COL - 1 && py == COLL_LINE) begin
        smp_valid = 1'b1;
        smp_data  = 8'hA0;            // -96 -> row ROW_OFS+32 = 40
        model[COLL_COL] = 8'hA0;
      end
      px++;
      if (px == H_TOT) begin
        px = 0;
        py = (py == V_TOT - 1) ? 0 : py + 1;
      end
      @(negedge clk);
    end
    smp_valid = 1'b0;
    check(hs_err == 0, "R3 hsync timing", hs_err, 0);
    check(vs_err == 0, "R4 vsync timing", vs_err, 0);
    check(rgb_err == 0, "R6 colours equal", rgb_err, 0);
    check(stray_blank == 0, "R7 blanking dark", stray_blank, 0);
    check(stray_cols == 0, "R7 columns 512+ dark", stray_cols, 0);
    // R8: old value row 44 and new value row 40 both miss: column stays dark
    check(lit_cnt[COLL_COL] == 0, "R8 read before write", lit_cnt[COLL_COL], 0);
    check(row_of(old_val) != COLL_LINE, "R8 setup", row_of(old_val), 44);
    // R1 wrap: entry 5 holds the 513th-batch value
    check(lit_row[5] == ROW_OFS + 62, "R1 wrap entry 5", lit_row[5], ROW_OFS + 62);
    // R5: -128 maps to the offset row itself
    check(lit_row[0] == ROW_OFS, "R5 min sample row", lit_row[0], ROW_OFS);
    check(lit_row[63] == ROW_OFS + 63, "R5 ramp top row", lit_row[63], ROW_OFS + 63);
    // R6 / R2: one aligned pixel per column at the mapped row
    for (int c = 0; c < DEPTH; c++) begin
      if (c != COLL_COL) begin
        check(lit_cnt[c] == 1, "R6 one pixel per column", lit_cnt[c], 1);
        check(lit_row[c] == row_of(model[c]), "R2 row alignment", lit_row[c], row_of(model[c]));
      end
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    t_reset_state();
    t_preload();
    t_rewrite_wrap();
    t_frame_scan();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

endmodule